// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a memory that keeps its contents on a backup cell when the main supply is lost. Two supply-monitor flags arrive from analog comparators. One says the supply is under the deselect threshold. The other says it is under the lower threshold at which the memory must run from the backup cell. A third input reports that a memory access is in progress. From these the block drives three outputs: a protect signal that forces the memory interface inactive, a backup-select signal for the power switch, and a ready indication.

When the supply fails, an access that has already started may finish, but only inside a bounded grace window counted in microseconds. After that window, protection is forced. When the supply comes back, protection is held for a recovery period counted in milliseconds, and only then is ready reported. A renewed failure during recovery sends the machine back through the failure path without ever releasing protection.

Each monitor flag passes through a two-flop synchronizer and then an N-cycle glitch filter before the state machine sees it. After reset the block starts protected, with the backup cell deselected, and it must complete a full recovery period before it reports ready.

Top module: `pfs_supervisor`

## Requirements
- R1: In the cycle after reset is released, protect_o=1, battery_sel_o=0 and ready_o=0. With the supply good, ready_o first rises after a full recovery period.
- R2: If supply_low_i rises while access_busy_i=0 and the block is ready, protect_o rises within FILT_LEN+6 cycles and ready_o falls.
- R3: If supply_low_i rises while access_busy_i=1, protect_o stays low while the access continues inside the grace window. It rises one or two cycles after access_busy_i falls.
- R4: If access_busy_i stays high, protect_o is forced high no earlier than WP_US microseconds after the failure is filtered, and no later than WP_US microseconds plus FILT_LEN+6 cycles after supply_low_i rises.
- R5: While protected, toggling access_busy_i changes none of the outputs.
- R6: While protected, supply_sw_i=1 (supply under the switchover threshold) sets battery_sel_o=1 within FILT_LEN+6 cycles. protect_o stays 1 throughout.
- R7: When supply_sw_i returns to 0, battery_sel_o falls within FILT_LEN+6 cycles while protect_o stays 1.
- R8: After supply_low_i falls, protect_o stays 1 for at least REC_MS milliseconds. ready_o then rises, with protect_o=0, no later than REC_MS milliseconds plus FILT_LEN+6 cycles after the fall.
- R9: If supply_low_i rises again during recovery, protect_o never drops. The recovery period restarts in full from the next return of the supply.
- R10: A pulse on supply_low_i lasting fewer than FILT_LEN cycles has no effect on any output.
- R11: battery_sel_o=1 only while protect_o=1, and ready_o=1 only while protect_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_low_i | input | 1 | Asynchronous flag: supply under the deselect threshold |
| supply_sw_i | input | 1 | Asynchronous flag: supply under the switchover threshold |
| access_busy_i | input | 1 | A memory access is in progress (synchronous) |
| protect_o | output | 1 | Forces the memory interface inactive |
| battery_sel_o | output | 1 | Selects the backup cell as memory power |
| ready_o | output | 1 | Normal operation allowed |

## Verification
The assertions assume that access_busy_i is already synchronous to clk. They also assume the switchover flag is only raised while the deselect flag is raised, which matches the physical ordering of the two thresholds. The stimulus changes every input just after a falling edge. It raises supply_sw_i only after supply_low_i is high and the block is protected, and drops supply_sw_i before supply_low_i. Glitch pulses are kept shorter than the filter length, and real level changes are held longer than it.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_PENDING = 3'd1,
        ST_PROTECT = 3'd2,
        ST_BATTERY = 3'd3,
        ST_RECOVER = 3'd4
    } pfs_state_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_PFD  = 0;
    localparam int FLAG_SW   = 1;

    typedef struct packed {
        logic below_sw;
        logic below_pfd;
    } pfs_flags_t;

    // Reset value of each filtered flag: assume the supply is bad until seen good
    function automatic logic flag_reset_val(input int idx);
        return (idx == FLAG_PFD);
    endfunction

    // Counter width able to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pfs_flag_filter.sv
module pfs_flag_filter
    import pfs_pkg::*;
#(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = cnt_w(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          s1_q, s2_q, filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= RST_VAL;
            s2_q   <= RST_VAL;
            filt_q <= RST_VAL;
            cnt_q  <= '0;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            if (s2_q == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                filt_q <= s2_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign filt_o = filt_q;

    // R10: the filtered flag only moves after a full run of agreeing samples
    a_r10_filter_run: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(s2_q) == filt_q) && ($past(cnt_q) == LAST));

endmodule

// File: rtl/pfs_tick_gen.sv
module pfs_tick_gen
    import pfs_pkg::*;
#(
    parameter int CLKS_PER_US = 250,
    parameter int US_PER_MS   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic us_tick_o,
    output logic ms_tick_o
);
    localparam int CCW = cnt_w(CLKS_PER_US);
    localparam int UCW = cnt_w(US_PER_MS);

    logic [CCW-1:0] cyc_q;
    logic [UCW-1:0] us_q;

    assign us_tick_o = (cyc_q == CCW'(CLKS_PER_US - 1));
    assign ms_tick_o = us_tick_o && (us_q == UCW'(US_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cyc_q <= '0;
            us_q  <= '0;
        end else if (us_tick_o) begin
            cyc_q <= '0;
            us_q  <= ms_tick_o ? '0 : us_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R4: microsecond counter never passes its wrap value
    a_r4_us_range: assert property (@(posedge clk) disable iff (rst)
        us_q <= UCW'(US_PER_MS - 1));

endmodule

// File: rtl/pfs_seq_fsm.sv
module pfs_seq_fsm
    import pfs_pkg::*;
#(
    parameter int WP_US  = 150,
    parameter int REC_MS = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  pfs_flags_t flags_i,
    input  logic       access_busy_i,
    input  logic       us_tick_i,
    input  logic       ms_tick_i,
    output logic       timer_clr_o,
    output logic       protect_o,
    output logic       battery_sel_o,
    output logic       ready_o
);
    localparam int WCW = cnt_w(WP_US);
    localparam int RCW = cnt_w(REC_MS);

    pfs_state_e     state_q, state_d;
    logic           grace_q, grace_d;
    logic [WCW-1:0] wp_cnt_q;
    logic [RCW-1:0] rec_cnt_q;
    logic           wp_done, rec_done;

    assign wp_done  = us_tick_i && (wp_cnt_q == WCW'(WP_US - 1));
    assign rec_done = ms_tick_i && (rec_cnt_q == RCW'(REC_MS - 1));

    always_comb begin
        state_d = state_q;
        grace_d = grace_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (flags_i.below_pfd) begin
                    state_d = ST_PENDING;
                    grace_d = 1'b1;
                end
            end
            ST_PENDING: begin
                if (!grace_q || !access_busy_i || flags_i.below_sw || wp_done)
                    state_d = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (flags_i.below_sw)        state_d = ST_BATTERY;
                else if (!flags_i.below_pfd) state_d = ST_RECOVER;
            end
            ST_BATTERY: begin
                if (!flags_i.below_sw) state_d = ST_PROTECT;
            end
            ST_RECOVER: begin
                if (flags_i.below_pfd) begin
                    state_d = ST_PENDING;
                    grace_d = 1'b0;
                end else if (rec_done) begin
                    state_d = ST_NORMAL;
                end
            end
            default: state_d = ST_PROTECT;
        endcase
    end

    assign timer_clr_o = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_PROTECT;
            grace_q   <= 1'b0;
            wp_cnt_q  <= '0;
            rec_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            grace_q <= grace_d;
            if (timer_clr_o) begin
                wp_cnt_q  <= '0;
                rec_cnt_q <= '0;
            end else begin
                if (state_q == ST_PENDING && us_tick_i) wp_cnt_q  <= wp_cnt_q + 1'b1;
                if (state_q == ST_RECOVER && ms_tick_i) rec_cnt_q <= rec_cnt_q + 1'b1;
            end
        end
    end

    assign protect_o     = !((state_q == ST_NORMAL) || (state_q == ST_PENDING && grace_q));
    assign battery_sel_o = (state_q == ST_BATTERY);
    assign ready_o       = (state_q == ST_NORMAL);

    // R11: backup selection only under protection
    a_r11_bat_protected: assert property (@(posedge clk) disable iff (rst)
        battery_sel_o |-> protect_o);

    // R8: ready appears only at the end of a completed recovery count
    a_r8_ready_source: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> ($past(state_q) == ST_RECOVER) && $past(ms_tick_i));

    // R4: the grace window counter stays inside its bound
    a_r4_wp_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING) |-> (wp_cnt_q < WCW'(WP_US)));

    // R3: an idle bus during a pending failure protects on the next cycle
    a_r3_idle_protects: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && !access_busy_i) |=> protect_o);

    // R9: renewed failure during recovery keeps protection
    a_r9_hold_in_recovery: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOVER && flags_i.below_pfd) |=> protect_o);

    // R7: leaving backup power keeps protection
    a_r7_bat_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(battery_sel_o) |-> protect_o);

    // R6: switchover while protected selects backup next cycle
    a_r6_bat_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROTECT && flags_i.below_sw) |=> battery_sel_o);

endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int CLKS_PER_US = 250,
    parameter int US_PER_MS   = 1000,
    parameter int WP_US       = 150,
    parameter int REC_MS      = 40,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low_i,
    input  logic supply_sw_i,
    input  logic access_busy_i,
    output logic protect_o,
    output logic battery_sel_o,
    output logic ready_o
);
    logic [NUM_FLAGS-1:0] raw_flags, filt_flags;
    pfs_flags_t           flags;
    logic                 us_tick, ms_tick, timer_clr;

    assign raw_flags[FLAG_PFD] = supply_low_i;
    assign raw_flags[FLAG_SW]  = supply_sw_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        pfs_flag_filter #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (flag_reset_val(g))
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_flags[g]),
            .filt_o (filt_flags[g])
        );
    end

    assign flags.below_pfd = filt_flags[FLAG_PFD];
    assign flags.below_sw  = filt_flags[FLAG_SW];

    pfs_tick_gen #(
        .CLKS_PER_US (CLKS_PER_US),
        .US_PER_MS   (US_PER_MS)
    ) u_ticks (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (timer_clr),
        .us_tick_o (us_tick),
        .ms_tick_o (ms_tick)
    );

    pfs_seq_fsm #(
        .WP_US  (WP_US),
        .REC_MS (REC_MS)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .flags_i       (flags),
        .access_busy_i (access_busy_i),
        .us_tick_i     (us_tick),
        .ms_tick_i     (ms_tick),
        .timer_clr_o   (timer_clr),
        .protect_o     (protect_o),
        .battery_sel_o (battery_sel_o),
        .ready_o       (ready_o)
    );

endmodule

// File: tb/tb_pfs_supervisor.sv
module tb_pfs_supervisor;

    localparam int K      = 4;
    localparam int M      = 8;
    localparam int WP     = 10;
    localparam int REC    = 3;
    localparam int FL     = 4;
    localparam int LAT    = FL + 6;
    localparam int REC_CY = REC * M * K;
    localparam int WP_CY  = WP * K;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lo = 1'b0, sw = 1'b0, busy = 1'b0;
    logic prot, bat, rdy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pfs_supervisor #(
        .CLKS_PER_US (K),
        .US_PER_MS   (M),
        .WP_US       (WP),
        .REC_MS      (REC),
        .FILT_LEN    (FL)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .supply_low_i  (lo),
        .supply_sw_i   (sw),
        .access_busy_i (busy),
        .protect_o     (prot),
        .battery_sel_o (bat),
        .ready_o       (rdy)
    );

    typedef struct {
        logic  p;
        logic  b;
        logic  r;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Driver side: queue the outputs expected at the next falling edge
    task automatic expect_out(input logic p, input logic b, input logic r, input string tag);
        exp_t e;
        e.p = p; e.b = b; e.r = r; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if ({prot, bat, rdy} !== {e.p, e.b, e.r}) begin
                n_fail++;
                $display("FAIL %s: prot/bat/rdy actual %b%b%b expected %b%b%b",
                         e.tag, prot, bat, rdy, e.p, e.b, e.r);
            end
        end
    end

    task automatic check_range(input string tag, input int act, input int lo_b, input int hi_b);
        n_checks++;
        if (act < lo_b || act > hi_b) begin
            n_fail++;
            $display("FAIL %s: latency actual %0d expected %0d..%0d", tag, act, lo_b, hi_b);
        end
    endtask

    // Count falling edges until the chosen output reaches val (0 prot, 1 bat, 2 rdy)
    task automatic wait_for(input int which, input logic val, input int limit,
                            output int cyc, output int prot_drops);
        logic cur;
        cyc = 0;
        prot_drops = 0;
        cur = ~val;
        while (cur !== val && cyc < limit) begin
            @(negedge clk);
            cyc++;
            cur = (which == 0) ? prot : (which == 1) ? bat : rdy;
            if (which == 2 && !prot && !rdy) prot_drops++;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        int c, d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R1: reset state then full recovery before ready
        expect_out(1'b1, 1'b0, 1'b0, "R1 reset state");
        wait_for(2, 1'b1, 1000, c, d);
        check_range("R1 ready after recovery", c + 1, REC_CY, REC_CY + LAT);
        expect_out(1'b0, 1'b0, 1'b1, "R1 ready state");

        // R10: glitch shorter than filter is ignored
        lo = 1'b1;
        repeat (FL - 1) @(negedge clk);
        lo = 1'b0;
        for (int i = 0; i < 12; i++) expect_out(1'b0, 1'b0, 1'b1, "R10 glitch ignored");

        // R2: failure with idle bus
        lo = 1'b1;
        wait_for(0, 1'b1, 200, c, d);
        check_range("R2 protect latency", c, 1, LAT);
        expect_out(1'b1, 1'b0, 1'b0, "R2 protected state");

        // R5: busy toggles ignored while protected
        for (int i = 0; i < 10; i++) begin
            busy = ~busy;
            expect_out(1'b1, 1'b0, 1'b0, "R5 busy ignored");
        end
        busy = 1'b0;

        // R6: switchover selects backup
        sw = 1'b1;
        wait_for(1, 1'b1, 200, c, d);
        check_range("R6 backup select latency", c, 1, LAT);
        expect_out(1'b1, 1'b1, 1'b0, "R6 backup state");

        // R7: supply above switchover deselects backup
        sw = 1'b0;
        wait_for(1, 1'b0, 200, c, d);
        check_range("R7 backup release latency", c, 1, LAT);
        expect_out(1'b1, 1'b0, 1'b0, "R7 still protected");

        // R8: recovery period
        lo = 1'b0;
        wait_for(2, 1'b1, 1000, c, d);
        check_range("R8 recovery length", c, REC_CY, REC_CY + LAT);
        check_range("R8 no early release", d, 0, 0);
        expect_out(1'b0, 1'b0, 1'b1, "R8 normal state");

        // R3: access in progress may finish
        busy = 1'b1;
        lo = 1'b1;
        repeat (LAT + 4) @(negedge clk);
        expect_out(1'b0, 1'b0, 1'b0, "R3 access allowed to finish");
        busy = 1'b0;
        wait_for(0, 1'b1, 200, c, d);
        check_range("R3 protect after access end", c, 1, 2);
        lo = 1'b0;
        wait_for(2, 1'b1, 1000, c, d);

        // R4: forced protection after the grace window
        busy = 1'b1;
        lo = 1'b1;
        wait_for(0, 1'b1, 1000, c, d);
        check_range("R4 forced protect", c, WP_CY, WP_CY + LAT);
        expect_out(1'b1, 1'b0, 1'b0, "R4 protected state");
        busy = 1'b0;

        // R9: renewed failure during recovery
        lo = 1'b0;
        repeat (40) @(negedge clk);
        lo = 1'b1;
        for (int i = 0; i < 20; i++) expect_out(1'b1, 1'b0, 1'b0, "R9 protect held");
        lo = 1'b0;
        wait_for(2, 1'b1, 1000, c, d);
        check_range("R9 full recovery restart", c, REC_CY, REC_CY + LAT);
        check_range("R9 no release during recovery", d, 0, 0);
        expect_out(1'b0, 1'b0, 1'b1, "R11 ready without protect");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule